// File: doc/BRIEF.md
# Four-Mode Arithmetic Unit with Overflow Flag

This block is a purely combinational adder of parameterised width (default 4 bits). Two operands, a carry-in bit and a 2-bit operation code go in; an n-bit result, a carry-out bit and a single overflow flag come out. The operation code picks one of four operations. Each operation has its own rule for raising the overflow flag, so one flag always means "the true result does not fit" for the number format of the chosen operation.

Signed values are two's complement. Subtraction is formed as `a + ~b + 1`. Negation is formed as `~b + 1`, and operand `a` plays no part in it. The carry input is used only by the two addition operations. The carry output is always the raw carry leaving the most significant bit of the internal adder. Outputs follow the inputs in the same cycle, since the block has no clock and no state.

Top module: `ovf_arith_unit`

## Requirements
- R1: With `op` = 2'b00 (unsigned add), `{carry_o, res}` equals the unsigned sum `a + b + carry_i` taken over n+1 bits.
- R2: With `op` = 2'b00, `ovf` equals `carry_o`.
- R3: With `op` = 2'b01 (signed add), `res` and `carry_o` are the same as in R1. `ovf` is 1 exactly when the two's-complement value of `a + b + carry_i` lies outside -2^(n-1) .. 2^(n-1)-1, which happens when the sign bits of `a` and `b` match and the sign bit of `res` differs from them.
- R4: With `op` = 2'b01, operands whose sign bits (bit n-1) differ never raise `ovf`.
- R5: With `op` = 2'b10 (signed subtract), `res` equals `(a - b) mod 2^n`. `carry_o` is the carry out of `a + ~b + 1`, which is 1 exactly when `a >= b` as unsigned values. `carry_i` has no effect.
- R6: With `op` = 2'b10, `ovf` is 1 exactly when the signed difference `a - b` is out of range: the sign bits of `a` and `b` differ and the sign bit of `res` differs from that of `a`.
- R7: With `op` = 2'b11 (negate), `res` equals `(-b) mod 2^n` and `carry_o` is 1 exactly when `b` is zero. Neither `a` nor `carry_i` has any effect.
- R8: With `op` = 2'b11, `ovf` is 1 exactly when `b` is a 1 in bit n-1 with all lower bits 0. In that case `res` equals `b`.
- R9: The block is combinational. All outputs are valid for the current inputs with no clock, and an all-zero input gives an all-zero output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand; unused in negate mode |
| b | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0; used only by the add modes |
| op | input | 2 | Operation: 00 unsigned add, 01 signed add, 10 signed subtract, 11 negate b |
| res | output | WIDTH | Result bits |
| carry_o | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Overflow under the rule of the selected operation |

## Verification
The hardest case to reach is the single negate input that cannot be represented: one bit pattern of `b`, seen only in mode 11. The nearby `b` = 0 case, the only negate input that produces a carry, is just as narrow. Both are reached by an exhaustive sweep over every operation code, every pair of operands and both carry-in values at the default width. Each vector is compared with an integer model that computes the true signed and unsigned results and judges the range directly. This also covers each boundary where a signed sum or difference just crosses a limit, and it shows that `a` and `carry_i` are ignored wherever R5 and R7 say so.

// File: rtl/ovf_arith_pkg.sv
package ovf_arith_pkg;

   typedef enum logic [1:0] {
      OP_UADD = 2'b00,
      OP_SADD = 2'b01,
      OP_SSUB = 2'b10,
      OP_NEGB = 2'b11
   } arith_op_e;

   localparam int ARCH_RIPPLE = 0;
   localparam int ARCH_INFER  = 1;

endpackage

// File: rtl/ovf_opnd_prep.sv
module ovf_opnd_prep
   import ovf_arith_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  arith_op_e          op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic               carry_i,
   output logic [WIDTH-1:0]   lhs,
   output logic [WIDTH-1:0]   rhs,
   output logic               cin
);

   logic invert_b;
   logic zero_a;

   always_comb begin
      invert_b = (op == OP_SSUB) || (op == OP_NEGB);
      zero_a   = (op == OP_NEGB);
      lhs      = zero_a   ? '0 : a;
      rhs      = invert_b ? ~b : b;
      cin      = invert_b ? 1'b1 : carry_i;
   end

endmodule

// File: rtl/ovf_core_add.sv
module ovf_core_add
   import ovf_arith_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int ARCH  = ARCH_RIPPLE
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co
);

   localparam int TOTAL = WIDTH + 1;

   generate
      if (ARCH == ARCH_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = ci;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic half;
            assign half          = x[i] ^ y[i];
            assign sum[i]        = half ^ chain[i];
            assign chain[i + 1]  = (x[i] & y[i]) | (chain[i] & half);
         end
         assign co = chain[WIDTH];
      end else begin : g_infer
         logic [TOTAL-1:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
         assign sum  = wide[WIDTH-1:0];
         assign co   = wide[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/ovf_flag_sel.sv
module ovf_flag_sel
   import ovf_arith_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  arith_op_e          op,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic [WIDTH-1:0]   sum,
   input  logic               co,
   output logic               ovf
);

   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic sa, sb, ss;
   logic add_rule, sub_rule, neg_rule;

   always_comb begin
      sa       = a[MSB];
      sb       = b[MSB];
      ss       = sum[MSB];
      add_rule = ~(sa ^ sb) & (sb ^ ss);
      sub_rule = (sa ^ sb) & (sa ^ ss);
      neg_rule = (b == MOST_NEG);
      unique case (op)
         OP_UADD: ovf = co;
         OP_SADD: ovf = add_rule;
         OP_SSUB: ovf = sub_rule;
         OP_NEGB: ovf = neg_rule;
         default: ovf = 1'b0;
      endcase
   end

   always_comb begin
      if (op == OP_SADD && (a[MSB] != b[MSB]))
         AST_OPPOSITE_SIGN_ADD: assert (!ovf) else $error("signed add of mixed signs flagged"); // R4
      if (op == OP_SSUB && (a[MSB] == b[MSB]))
         AST_SAME_SIGN_SUB: assert (!ovf) else $error("same-sign subtract flagged"); // R6
   end

endmodule

// File: rtl/ovf_arith_unit.sv
module ovf_arith_unit
   import ovf_arith_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int ARCH  = ARCH_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             carry_i,
   input  logic [1:0]       op,
   output logic [WIDTH-1:0] res,
   output logic             carry_o,
   output logic             ovf
);

   localparam int TOTAL = WIDTH + 1;
   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ovf_arith_unit: WIDTH must be at least 2");
      end
      if (ARCH != ARCH_RIPPLE && ARCH != ARCH_INFER) begin : g_bad_arch
         $error("ovf_arith_unit: ARCH must select ripple or inferred adder");
      end
   endgenerate

   arith_op_e        op_e;
   logic [WIDTH-1:0] lhs, rhs;
   logic             cin;

   assign op_e = arith_op_e'(op);

   ovf_opnd_prep #(.WIDTH(WIDTH)) u_prep (
      .op      (op_e),
      .a       (a),
      .b       (b),
      .carry_i (carry_i),
      .lhs     (lhs),
      .rhs     (rhs),
      .cin     (cin)
   );

   ovf_core_add #(.WIDTH(WIDTH), .ARCH(ARCH)) u_add (
      .x   (lhs),
      .y   (rhs),
      .ci  (cin),
      .sum (res),
      .co  (carry_o)
   );

   ovf_flag_sel #(.WIDTH(WIDTH)) u_flag (
      .op  (op_e),
      .a   (a),
      .b   (b),
      .sum (res),
      .co  (carry_o),
      .ovf (ovf)
   );

   logic [TOTAL-1:0] plain_sum;
   assign plain_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_i};

   always_comb begin
      if (op_e == OP_UADD)
         AST_UADD_RESULT: assert ({carry_o, res} == plain_sum) else $error("unsigned add result wrong"); // R1
      if (op_e == OP_NEGB && ovf)
         AST_NEG_WRAPS_SELF: assert (res == b && b == MOST_NEG) else $error("negate overflow without wrap"); // R8
      if (op_e == OP_NEGB && b == '0)
         AST_NEG_ZERO_CARRY: assert (carry_o && res == '0) else $error("negate of zero lost carry"); // R7
   end

endmodule

// File: tb/sim_ovf_arith_unit.sv
module sim_ovf_arith_unit;

   localparam int W       = 4;
   localparam int CLK_PER = 10;
   localparam int SPAN    = 1 << W;
   localparam int HALF    = 1 << (W - 1);

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a = '0, b = '0;
   logic         carry_i = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [W-1:0] res;
   logic         carry_o, ovf;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct {
      logic [W-1:0] s;
      logic         c;
      logic         v;
      string        rs;
      string        rv;
      string        tag;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PER/2) clk = ~clk;

   ovf_arith_unit #(.WIDTH(W)) u0 (
      .a(a), .b(b), .carry_i(carry_i), .op(op),
      .res(res), .carry_o(carry_o), .ovf(ovf)
   );

   function automatic int to_signed(int u);
      return (u >= HALF) ? u - SPAN : u;
   endfunction

   task automatic drive(int m, int ua, int ub, int ci);
      exp_t e;
      int tot, sv;
      @(posedge clk);
      a = W'(ua); b = W'(ub); carry_i = ci[0]; op = m[1:0];
      case (m)
         0: begin tot = ua + ub + ci; sv = 0; e.rs = "R1"; e.rv = "R2"; end
         1: begin tot = ua + ub + ci; sv = to_signed(ua) + to_signed(ub) + ci;
                  e.rs = "R3";
                  e.rv = ((ua >= HALF) != (ub >= HALF)) ? "R4" : "R3"; end
         2: begin tot = ua + ((~ub) & (SPAN - 1)) + 1; sv = to_signed(ua) - to_signed(ub);
                  e.rs = "R5"; e.rv = "R6"; end
         default: begin tot = ((~ub) & (SPAN - 1)) + 1; sv = -to_signed(ub);
                  e.rs = "R7"; e.rv = "R8"; end
      endcase
      e.s = W'(tot % SPAN);
      e.c = (tot >= SPAN);
      if (m == 0) e.v = e.c;
      else        e.v = (sv > HALF - 1) || (sv < -HALF);
      e.tag = $sformatf("op=%0d a=%0d b=%0d ci=%0d", m, ua, ub, ci);
      sb_q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (res !== e.s) begin
               fails++;
               $display("FAIL %s res %s: got %0d expected %0d", e.rs, e.tag, res, e.s);
            end
            checks++;
            if (carry_o !== e.c) begin
               fails++;
               $display("FAIL %s carry %s: got %0b expected %0b", e.rs, e.tag, carry_o, e.c);
            end
            checks++;
            if (ovf !== e.v) begin
               fails++;
               $display("FAIL %s ovf %s: got %0b expected %0b", e.rv, e.tag, ovf, e.v);
            end
         end
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R9: all-zero inputs give all-zero outputs, settled without any clock edge
      @(negedge clk);
      checks++;
      if (res !== '0 || carry_o !== 1'b0 || ovf !== 1'b0) begin
         fails++;
         $display("FAIL R9 idle outputs: got %0d/%0b/%0b expected 0/0/0", res, carry_o, ovf);
      end
      for (int m = 0; m < 4; m++)
         for (int ua = 0; ua < SPAN; ua++)
            for (int ub = 0; ub < SPAN; ub++)
               for (int ci = 0; ci < 2; ci++)
                  drive(m, ua, ub, ci);
      // R8 and R7 corners once more with varied a to show a is ignored
      drive(3, SPAN - 1, HALF, 1);
      drive(3, 5, 0, 0);
      // R5 carry_i ignored at the signed-limit crossing
      drive(2, HALF - 1, SPAN - 1, 1);
      while (sb_q.size() > 0) @(posedge clk);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule